// File: doc/BRIEF.md
# External Memory Strobe Pulse Generator

This block produces the active-low chip-select (`ncs_n`), read-strobe (`nrd_n`) and write-strobe (`nwe_n`) pulses for one access to an external static memory. Each chip-select region has its own 32-bit timing word, held in a small register file that software writes and reads through a simple address/data port. Each timing word packs four 7-bit width fields. A field uses a two-range code: its top bit is worth 256 clocks and its low six bits add a fine count of clocks.

A controller starts an access by pulsing `start` with a chip-select index, a read/write flag, a page-mode flag and a first-in-page flag. All strobes that take part in the access go low on the next clock. Each strobe returns high on its own when its width has run out. When every strobe is high again, `done` pulses for one clock. Setup, hold, cycle length, address and data handling, and wait states belong to the surrounding controller.

Top module: `extmem_strobe_gen`

## Requirements
- R1: Timing word n sits at byte address 0x04 + 0x10·n for n below NUM_CS, and resets to 0x01010101.
- R2: Bits 31, 23, 15 and 7 of a timing word always read as zero. Writing to them has no effect. An address that matches no timing word reads as zero, and a write to it changes nothing.
- R3: A 7-bit width field f stands for 256·f[6] + f[5:0] clock cycles.
- R4: A field that decodes to zero gives a one-clock pulse.
- R5: A standard read holds `ncs_n` low for the width in bits 30:24 and `nrd_n` low for the width in bits 22:16. `nwe_n` stays high.
- R6: A write holds `ncs_n` low for the width in bits 14:8 and `nwe_n` low for the width in bits 6:0. `nrd_n` stays high.
- R7: A page-mode read with `start_first`=1 holds both `ncs_n` and `nrd_n` low for the width in bits 30:24.
- R8: A page-mode read with `start_first`=0 holds both `ncs_n` and `nrd_n` low for the width in bits 22:16.
- R9: An accepted start pulls the active strobes low in the first cycle after the clock edge that samples it. Each strobe then stays low for one unbroken run. No strobe is low while the block is idle.
- R10: `done` is high for exactly one cycle: the first cycle in which every strobe of the access is high again. That is cycle max(width)+1 after the start edge.
- R11: A start that arrives while an access is running, including during its `done` cycle, is ignored.
- R12: The page-mode flag has no effect on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| start | input | 1 | Access request |
| start_cs | input | CS_W | Chip-select index of the request |
| start_wr | input | 1 | 1 = write, 0 = read |
| start_page | input | 1 | Page-mode read |
| start_first | input | 1 | First access in the page |
| ncs_n | output | 1 | Chip select, active low |
| nrd_n | output | 1 | Read strobe, active low |
| nwe_n | output | 1 | Write strobe, active low |
| done | output | 1 | One-cycle end-of-access flag |

## Verification
The bench sweeps field values that cover both ranges of the width code: zero, one, small values, 63, 256 and above, and the largest code, 319 clocks. It runs every access kind on every chip select. A decoder that drops the 256 weight, or that lets a zero field make a zero-length or missing pulse, shows up as a wrong count of low cycles. Mixing up the page-mode first and later widths, or using the wrong field for a write, makes the strobe lengths differ from the widths the bench computes itself. A stray start is sent during every access, and some accesses finish with `done` on cycle 2. A design that restarts during the access or during its `done` cycle would show a second or broken strobe run, or a `done` that comes late or twice.

// File: rtl/extmem_strobe_pkg.sv
// Shared types and the width decoder for the strobe generator.
// Assumes a 32-bit timing word with four 7-bit fields, each with a spare top bit.
package extmem_strobe_pkg;

    localparam int FIELD_W = 7;
    localparam int LEN_W   = 9;   // holds up to 256 + 63
    localparam logic [31:0] TIMING_RESET = 32'h0101_0101;
    localparam logic [31:0] TIMING_MASK  = 32'h7F7F_7F7F;

    typedef struct packed {
        logic               spare3;
        logic [FIELD_W-1:0] cs_rd_w;   // chip select, read access
        logic               spare2;
        logic [FIELD_W-1:0] rd_w;      // read strobe
        logic               spare1;
        logic [FIELD_W-1:0] cs_wr_w;   // chip select, write access
        logic               spare0;
        logic [FIELD_W-1:0] we_w;      // write strobe
    } timing_word_t;

    // Two-range width code: bit 6 adds 256 clocks, bits 5:0 add the fine count; zero becomes one.
    function automatic logic [LEN_W-1:0] width_of(input logic [FIELD_W-1:0] f);
        logic [LEN_W-1:0] v;
        v = {f[6], 2'b00, f[5:0]};
        if (v == '0) v = LEN_W'(1);
        return v;
    endfunction

endpackage

// File: rtl/extmem_timing_regs.sv
// Timing word storage, one 32-bit word per chip select, at byte address 0x04 + 0x10*n.
// Assumes single-cycle writes and a combinational read. Spare bits are stored as zero.
module extmem_timing_regs
    import extmem_strobe_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    output logic [NUM_CS-1:0][31:0] words
);
    localparam int IDX_W = ADDR_W - 4;
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

    logic [IDX_W-1:0] idx;
    logic             hit;

    // Address decode: word offset 4 inside a 16-byte slot whose index is a valid chip select.
    always_comb begin
        idx = reg_addr[ADDR_W-1:4];
        hit = (reg_addr[3:0] == 4'h4) && (idx < IDX_W'(NUM_CS));
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_word
        // Holds one timing word; only its own slot writes it, with spare bits masked off.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[g] <= TIMING_RESET;
            else if (reg_we && hit && idx == IDX_W'(g))
                words[g] <= reg_wdata & TIMING_MASK;
        end
    end

    // Read mux: the addressed word, or zero when nothing matches.
    always_comb begin
        reg_rdata = '0;
        if (hit) reg_rdata = words[idx[CS_W-1:0]];
    end
endmodule

// File: rtl/extmem_strobe_timer.sv
// Down-counter for one strobe. Loading a nonzero width drives the strobe low for exactly
// that many cycles; loading zero leaves it high. Assumes the load value fits LEN_W bits.
module extmem_strobe_timer
    import extmem_strobe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    output logic             strobe_n,
    output logic             idle
);
    logic [LEN_W-1:0] remain;

    // Counts the remaining low cycles of the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= load_len;
        else if (remain != '0)
            remain <= remain - LEN_W'(1);
    end

    // Strobe is low while cycles remain.
    always_comb begin
        idle     = (remain == '0);
        strobe_n = idle;
    end
endmodule

// File: rtl/extmem_strobe_gen.sv
// Strobe pulse generator for an external static memory. It accepts one access at a time,
// loads the widths for that access from the chip select's timing word, and flags the end.
// Assumes start_cs < NUM_CS and that the caller waits for done before relying on a new start.
module extmem_strobe_gen
    import extmem_strobe_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 8,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              start,
    input  logic [CS_W-1:0]   start_cs,
    input  logic              start_wr,
    input  logic              start_page,
    input  logic              start_first,
    output logic              ncs_n,
    output logic              nrd_n,
    output logic              nwe_n,
    output logic              done
);
    logic [NUM_CS-1:0][31:0] words;
    timing_word_t            tw;
    logic [LEN_W-1:0]        len_cs, len_rd, len_we, page_len;
    logic                    accept, active_q;
    logic                    cs_idle, rd_idle, we_idle;

    extmem_timing_regs #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .words(words)
    );

    // Width selection for the requested access kind.
    always_comb begin
        tw       = timing_word_t'(words[start_cs]);
        page_len = start_first ? width_of(tw.cs_rd_w) : width_of(tw.rd_w);
        len_cs   = '0;
        len_rd   = '0;
        len_we   = '0;
        if (start_wr) begin
            len_cs = width_of(tw.cs_wr_w);
            len_we = width_of(tw.we_w);
        end else if (start_page) begin
            len_cs = page_len;
            len_rd = page_len;
        end else begin
            len_cs = width_of(tw.cs_rd_w);
            len_rd = width_of(tw.rd_w);
        end
    end

    // Start acceptance and end-of-access detection.
    always_comb begin
        accept = start && !active_q;
        done   = active_q && cs_idle && rd_idle && we_idle;
    end

    // Access-in-progress flag: set on an accepted start, cleared after the done cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= 1'b0;
        else if (accept)
            active_q <= 1'b1;
        else if (done)
            active_q <= 1'b0;
    end

    extmem_strobe_timer cs_tmr_i (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_len(len_cs),
        .strobe_n(ncs_n), .idle(cs_idle)
    );
    extmem_strobe_timer rd_tmr_i (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_len(len_rd),
        .strobe_n(nrd_n), .idle(rd_idle)
    );
    extmem_strobe_timer we_tmr_i (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_len(len_we),
        .strobe_n(nwe_n), .idle(we_idle)
    );
endmodule

// File: rtl/extmem_strobe_gen_chk.sv
// Protocol checks on the strobe generator's ports and its busy flag.
module extmem_strobe_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic active_q,
    input logic ncs_n,
    input logic nrd_n,
    input logic nwe_n,
    input logic done
);
    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nrd_n && !nwe_n)); // R6
    AST_LOW_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !active_q) |=> !ncs_n); // R9
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> (ncs_n && nrd_n && nwe_n)); // R9
    AST_FALL_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ncs_n) |-> $past(start && !active_q)); // R11
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ncs_n && nrd_n && nwe_n)); // R10
endmodule

bind extmem_strobe_gen extmem_strobe_gen_chk chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .active_q(active_q),
    .ncs_n(ncs_n), .nrd_n(nrd_n), .nwe_n(nwe_n), .done(done)
);

// File: tb/extmem_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module extmem_strobe_gen_tb_top;
    localparam int NUM_CS = 4;
    localparam int ADDR_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        start = 1'b0;
    logic [1:0]  start_cs = '0;
    logic        start_wr = 1'b0, start_page = 1'b0, start_first = 1'b0;
    logic        ncs_n, nrd_n, nwe_n, done;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    extmem_strobe_gen #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start(start),
        .start_cs(start_cs), .start_wr(start_wr), .start_page(start_page),
        .start_first(start_first), .ncs_n(ncs_n), .nrd_n(nrd_n),
        .nwe_n(nwe_n), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int dec(input int f);
        int v;
        v = ((f >> 6) & 1) * 256 + (f & 63);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, req, int'(reg_rdata), int'(exp));
    endtask

    // Runs one access; widths of 0 mean the strobe must stay high.
    task automatic run_access(input int cs, input bit wr, input bit page, input bit first,
                              input int e_cs, input int e_rd, input int e_we, input string req);
        int n_cs = 0, n_rd = 0, n_we = 0, l_cs = 0, l_rd = 0, l_we = 0;
        int d_cnt = 0, d_at = 0, mx;
        @(negedge clk);
        start = 1'b1; start_cs = 2'(cs); start_wr = wr; start_page = page; start_first = first;
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c < 400; c++) begin
            if (c > 1) @(negedge clk);
            if (c == 3) start = 1'b0;
            if (!ncs_n) begin n_cs++; l_cs = c; end
            if (!nrd_n) begin n_rd++; l_rd = c; end
            if (!nwe_n) begin n_we++; l_we = c; end
            if (done) begin d_cnt++; if (d_at == 0) d_at = c; end
            if (c == 2) begin  // stray request while busy (R11)
                start = 1'b1; start_wr = !wr; start_cs = 2'(cs + 1); start_page = 1'b0;
            end
            if (d_at != 0 && c >= d_at + 2) break;
        end
        start = 1'b0;
        mx = e_cs;
        if (e_rd > mx) mx = e_rd;
        if (e_we > mx) mx = e_we;
        check(n_cs == e_cs && (e_cs == 0 || l_cs == e_cs), {req, " ncs width R9"}, n_cs, e_cs);
        check(n_rd == e_rd && (e_rd == 0 || l_rd == e_rd), {req, " nrd width R9"}, n_rd, e_rd);
        check(n_we == e_we && (e_we == 0 || l_we == e_we), {req, " nwe width R9"}, n_we, e_we);
        check(d_cnt == 1 && d_at == mx + 1, {req, " done R10 R11"}, d_at, mx + 1);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int vals[8] = '{0, 1, 2, 5, 63, 64, 65, 127};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values and addresses
        for (int n = 0; n < NUM_CS; n++) rd_check(8'(4 + 16 * n), 32'h0101_0101, "R1 reset word");
        check(ncs_n && nrd_n && nwe_n && !done, "R9 idle after reset", int'({ncs_n, nrd_n, nwe_n, done}), 14);
        // R2 spare bits and unmatched addresses
        wr_reg(8'h14, 32'hFFFF_FFFF);
        rd_check(8'h14, 32'h7F7F_7F7F, "R2 spare bits");
        rd_check(8'h04, 32'h0101_0101, "R1 neighbour untouched");
        wr_reg(8'h10, 32'h1234_5678);
        wr_reg(8'h08, 32'h1234_5678);
        wr_reg(8'h44, 32'h1234_5678);
        rd_check(8'h10, 32'h0, "R2 unmatched read");
        rd_check(8'h44, 32'h0, "R2 out-of-range read");
        for (int n = 0; n < NUM_CS; n++)
            rd_check(8'(4 + 16 * n), (n == 1) ? 32'h7F7F_7F7F : 32'h0101_0101, "R2 stray write ignored");
        // Reset-value access: every width is one clock
        run_access(0, 1'b0, 1'b0, 1'b0, 1, 1, 0, "R5 default read");
        // Sweep of field codes over all chip selects and access kinds (R3 R4)
        for (int i = 0; i < 8; i++) begin
            int f_csr, f_rd, f_csw, f_we, cs;
            f_csr = vals[i]; f_rd = vals[(i + 3) % 8]; f_csw = vals[(i + 5) % 8]; f_we = vals[(i + 1) % 8];
            cs = i % NUM_CS;
            wr_reg(8'(4 + 16 * cs), {1'b1, 7'(f_csr), 1'b1, 7'(f_rd), 1'b1, 7'(f_csw), 1'b1, 7'(f_we)});
            rd_check(8'(4 + 16 * cs), {1'b0, 7'(f_csr), 1'b0, 7'(f_rd), 1'b0, 7'(f_csw), 1'b0, 7'(f_we)},
                     "R2 field readback");
            run_access(cs, 1'b0, 1'b0, 1'b0, dec(f_csr), dec(f_rd), 0, "R3 R4 R5 standard read");
            run_access(cs, 1'b1, 1'b0, 1'b0, dec(f_csw), 0, dec(f_we), "R3 R4 R6 write");
            run_access(cs, 1'b0, 1'b1, 1'b1, dec(f_csr), dec(f_csr), 0, "R7 page first");
            run_access(cs, 1'b0, 1'b1, 1'b0, dec(f_rd), dec(f_rd), 0, "R8 page later");
            run_access(cs, 1'b1, 1'b1, 1'b1, dec(f_csw), 0, dec(f_we), "R12 page flag on write");
        end
        check(ncs_n && nrd_n && nwe_n && !done, "R9 idle at end", int'({ncs_n, nrd_n, nwe_n, done}), 14);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule